// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block is the command half of an SD host controller. Software loads a 32-bit argument, then writes a command word that holds the command index, the data direction flags and a response-type code. Setting the start flag in that word launches the engine. It generates the SD clock from the system clock through a programmable divider. It shifts a 48-bit command frame with its CRC7 onto the CMD line, then waits for the card's reply and captures it into four 32-bit response registers.

The engine reports problems in a write-one-to-clear status register: no response within the allowed window, a corrupt short response, or a card that stays busy too long. For busy-type commands it watches DAT0 and raises a status bit when the card releases the line. That bit can drive an interrupt output when enabled. Block data transfer on the DAT lines and card bring-up policy belong to other blocks.

Top module: `sdh_cmd_engine`

## Requirements
- R1: A launched command is sent MSB first, changing on falling SD clock edges, as 48 bits: 0, 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero seed) over those first 40 bits, and a final 1. CMD output enable is high only while the frame is driven.
- R2: Command word (offset 0x00): index bits 5:0, card-to-host bit 6, host-to-card bit 7, response type bits 11:9, failed bit 14, start bit 15. Writing it with bit 15 set launches a command. Start reads 1 until the command succeeds, then 0.
- R3: Response type 0 (48-bit reply) writes only the first response word (0x10), which receives the 32 bits after the 8 header bits of the reply. The words at 0x14, 0x18 and 0x1C keep their values.
- R4: Response type 1 (136-bit reply) writes all four response words with the last 128 reply bits, with 0x10 holding the least significant word. Its internal CRC is not checked.
- R5: Response type 2 (no reply) finishes right after the frame and leaves all response words unchanged.
- R6: If no reply start bit (0) is sampled within 64 rising SD clock edges after the frame, status bit 6 is set, and failed is set with start still 1.
- R7: A 48-bit reply whose 7 CRC bits do not match CRC7 of its first 40 bits sets status bit 4 and failed.
- R8: Response type 4 adds a wait for DAT0 to go high. Release sets status bit 10 and then clears start. The interrupt output equals status bit 10 AND bit 10 of the host config word (offset 0x38), one cycle late.
- R9: If DAT0 stays low for more than the cycle count in the timeout word (offset 0x08), status bit 7 and failed are set.
- R10: Status (offset 0x20) bits clear when written with 1. Bits written with 0 keep their value.
- R11: A command-word write while start is 1 and failed is 0 has no effect on the register or the CMD line.
- R12: The SD clock period is 2*(D+1) system clocks, where D is the clock divider word (offset 0x0C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after address |
| sd_clk | output | 1 | SD card clock |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |
| dat0_in | input | 1 | DAT0 level, low while the card is busy |
| irq | output | 1 | Busy-done interrupt |

## Verification
Assertions check the following on every cycle:
- the frame always releases the line on its final 1 bit;
- the wait counter never passes the 64-edge window;
- any rise of failed comes with an error status bit;
- the three upper response words change only on a long reply;
- the interrupt follows its enable;
- a write during a command leaves the command word alone;
- each divider strobe flips the SD clock.

Only the bench scenarios can show the rest:
- the exact frame bits and CRC for a sweep of indices and arguments;
- the reply capture for each response type;
- CRC failures;
- the busy and busy-timeout outcomes;
- the measured SD clock period.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int HDR_BITS   = 40;

  localparam logic [2:0] RT_SHORT = 3'd0;
  localparam logic [2:0] RT_LONG  = 3'd1;
  localparam logic [2:0] RT_NONE  = 3'd2;
  localparam logic [2:0] RT_BUSY  = 3'd4;

  localparam logic [7:0] A_CMD  = 8'h00;
  localparam logic [7:0] A_ARG  = 8'h04;
  localparam logic [7:0] A_TMO  = 8'h08;
  localparam logic [7:0] A_DIV  = 8'h0C;
  localparam logic [7:0] A_RSP0 = 8'h10;
  localparam logic [7:0] A_RSP1 = 8'h14;
  localparam logic [7:0] A_RSP2 = 8'h18;
  localparam logic [7:0] A_RSP3 = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_HCFG = 8'h38;

  localparam int ST_CRC   = 4;
  localparam int ST_CTO   = 6;
  localparam int ST_BTO   = 7;
  localparam int ST_BUSY  = 10;
  localparam logic [10:0] ST_MASK = 11'h7F9;
endpackage

// File: rtl/sdh_crc7.sv
module sdh_crc7 #(
  parameter int W = 40
) (
  input  logic [W-1:0] data,
  output logic [6:0]   crc
);
  always_comb begin
    logic fb;
    crc = 7'd0;
    for (int i = W - 1; i >= 0; i--) begin
      fb  = data[i] ^ crc[6];
      crc = {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
  end
endmodule

// File: rtl/sdh_clkgen.sv
module sdh_clkgen #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             sd_clk,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit      = (cnt >= div);
  assign rise_stb = hit & ~sd_clk;
  assign fall_stb = hit & sd_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sd_clk <= 1'b0;
    end else if (hit) begin
      cnt    <= '0;
      sd_clk <= ~sd_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SDCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (rise_stb | fall_stb) |=> (sd_clk != $past(sd_clk))); // R12
endmodule

// File: rtl/sdh_cmd_fsm.sv
module sdh_cmd_fsm
  import sdh_pkg::*;
#(
  parameter int WAIT_LIM = 64,
  parameter int TMO_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [5:0]       idx,
  input  logic [31:0]      arg,
  input  logic [2:0]       rtype,
  input  logic [TMO_W-1:0] tmo_lim,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             cmd_in,
  input  logic             dat0_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             fin,
  output logic             err_cto,
  output logic             err_crc,
  output logic             err_bto,
  output logic             busy_evt,
  output logic             rsp_we_short,
  output logic             rsp_we_long,
  output logic [127:0]     rsp_data
);
  localparam int CW = $clog2(LONG_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_CHK, S_BUSY} st_t;
  st_t st;

  logic [FRAME_BITS-1:0] txsh;
  logic [LONG_BITS-1:0]  rxsh;
  logic [CW-1:0]         cnt;
  logic [TMO_W-1:0]      bcnt;
  logic [2:0]            rt_q;
  logic [6:0]            tx_crc, rx_crc;
  logic                  is_long, is_none, is_busy;

  assign is_long = (rt_q == RT_LONG);
  assign is_none = (rt_q == RT_NONE);
  assign is_busy = (rt_q == RT_BUSY);
  assign rsp_data = is_long ? rxsh[127:0] : {96'd0, rxsh[39:8]};

  sdh_crc7 #(.W(HDR_BITS)) u_crc_tx (.data({2'b01, idx, arg}), .crc(tx_crc));
  sdh_crc7 #(.W(HDR_BITS)) u_crc_rx (.data(rxsh[47:8]), .crc(rx_crc));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; txsh <= '0; rxsh <= '0; cnt <= '0; bcnt <= '0; rt_q <= '0;
      cmd_out <= 1'b1; cmd_oe <= 1'b0;
      fin <= 1'b0; err_cto <= 1'b0; err_crc <= 1'b0; err_bto <= 1'b0;
      busy_evt <= 1'b0; rsp_we_short <= 1'b0; rsp_we_long <= 1'b0;
    end else begin
      fin <= 1'b0; err_cto <= 1'b0; err_crc <= 1'b0; err_bto <= 1'b0;
      busy_evt <= 1'b0; rsp_we_short <= 1'b0; rsp_we_long <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          txsh <= {2'b01, idx, arg, tx_crc, 1'b1};
          rxsh <= '0;
          rt_q <= rtype;
          cnt  <= '0;
          st   <= S_TX;
        end
        S_TX: if (fall_stb) begin
          if (cnt == CW'(FRAME_BITS)) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            cnt     <= '0;
            if (is_none) begin
              fin <= 1'b1;
              st  <= S_IDLE;
            end else begin
              st <= S_WAIT;
            end
          end else begin
            cmd_oe  <= 1'b1;
            cmd_out <= txsh[FRAME_BITS-1];
            txsh    <= {txsh[FRAME_BITS-2:0], 1'b0};
            cnt     <= cnt + 1'b1;
          end
        end
        S_WAIT: if (rise_stb) begin
          if (!cmd_in) begin
            rxsh <= {rxsh[LONG_BITS-2:0], cmd_in};
            cnt  <= CW'(1);
            st   <= S_RX;
          end else if (cnt == CW'(WAIT_LIM - 1)) begin
            fin     <= 1'b1;
            err_cto <= 1'b1;
            st      <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RX: if (rise_stb) begin
          rxsh <= {rxsh[LONG_BITS-2:0], cmd_in};
          cnt  <= cnt + 1'b1;
          if (cnt == (is_long ? CW'(LONG_BITS - 1) : CW'(FRAME_BITS - 1)))
            st <= S_CHK;
        end
        S_CHK: begin
          bcnt <= '0;
          if (is_long) begin
            rsp_we_long <= 1'b1;
            fin         <= 1'b1;
            st          <= S_IDLE;
          end else begin
            rsp_we_short <= 1'b1;
            if (rx_crc != rxsh[7:1]) begin
              err_crc <= 1'b1;
              fin     <= 1'b1;
              st      <= S_IDLE;
            end else if (is_busy) begin
              st <= S_BUSY;
            end else begin
              fin <= 1'b1;
              st  <= S_IDLE;
            end
          end
        end
        S_BUSY: begin
          if (dat0_in) begin
            busy_evt <= 1'b1;
            fin      <= 1'b1;
            st       <= S_IDLE;
          end else if (bcnt >= tmo_lim) begin
            err_bto <= 1'b1;
            fin     <= 1'b1;
            st      <= S_IDLE;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RELEASE_ON_END: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> ($past(cmd_out) && cmd_out)); // R1
  AST_WAIT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> (cnt < CW'(WAIT_LIM))); // R6
endmodule

// File: rtl/sdh_cmd_engine.sv
module sdh_cmd_engine
  import sdh_pkg::*;
#(
  parameter int          DIV_W    = 11,
  parameter int          TMO_W    = 32,
  parameter int          WAIT_LIM = 64,
  parameter logic [31:0] TMO_RST  = 32'h00F0_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sd_clk,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        irq
);
  logic [5:0]       idx_q;
  logic             c2h_q, h2c_q, start_q, failed_q;
  logic [2:0]       rt_q;
  logic [31:0]      arg_q;
  logic [TMO_W-1:0] tmo_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      rsp_q [4];
  logic [10:0]      stat_q;
  logic [10:0]      hcfg_q;

  logic rise_stb, fall_stb, go, in_flight, cmd_wr;
  logic fin, err_cto, err_crc, err_bto, busy_evt, we_s, we_l;
  logic [127:0] rsp_d;
  logic [10:0]  stat_set;

  assign in_flight = start_q & ~failed_q;
  assign cmd_wr    = bus_we && (bus_addr == A_CMD) && !in_flight;
  assign go        = cmd_wr && bus_wdata[15];
  assign stat_set  = (11'(err_crc) << ST_CRC) | (11'(err_cto) << ST_CTO) |
                     (11'(err_bto) << ST_BTO) | (11'(busy_evt) << ST_BUSY);

  sdh_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div(div_q),
    .sd_clk(sd_clk), .rise_stb(rise_stb), .fall_stb(fall_stb));

  sdh_cmd_fsm #(.WAIT_LIM(WAIT_LIM), .TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst(rst), .go(go), .idx(bus_wdata[5:0]), .arg(arg_q),
    .rtype(bus_wdata[11:9]), .tmo_lim(tmo_q),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .fin(fin),
    .err_cto(err_cto), .err_crc(err_crc), .err_bto(err_bto), .busy_evt(busy_evt),
    .rsp_we_short(we_s), .rsp_we_long(we_l), .rsp_data(rsp_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0; c2h_q <= 1'b0; h2c_q <= 1'b0; rt_q <= '0;
      start_q <= 1'b0; failed_q <= 1'b0;
      arg_q <= '0; tmo_q <= TMO_W'(TMO_RST); div_q <= '0;
      stat_q <= '0; hcfg_q <= '0; irq <= 1'b0;
      for (int i = 0; i < 4; i++) rsp_q[i] <= '0;
    end else begin
      irq <= stat_q[ST_BUSY] & hcfg_q[ST_BUSY];
      if (cmd_wr) begin
        idx_q    <= bus_wdata[5:0];
        c2h_q    <= bus_wdata[6];
        h2c_q    <= bus_wdata[7];
        rt_q     <= bus_wdata[11:9];
        start_q  <= bus_wdata[15];
        failed_q <= 1'b0;
      end else if (fin) begin
        if (err_cto | err_crc | err_bto) failed_q <= 1'b1;
        else                            start_q  <= 1'b0;
      end
      if (bus_we) begin
        case (bus_addr)
          A_ARG:   arg_q  <= bus_wdata;
          A_TMO:   tmo_q  <= bus_wdata[TMO_W-1:0];
          A_DIV:   div_q  <= bus_wdata[DIV_W-1:0];
          A_HCFG:  hcfg_q <= bus_wdata[10:0];
          default: ;
        endcase
      end
      stat_q <= ((bus_we && bus_addr == A_STAT) ? (stat_q & ~bus_wdata[10:0]) : stat_q)
                | (stat_set & ST_MASK);
      if (we_l) begin
        for (int i = 0; i < 4; i++) rsp_q[i] <= rsp_d[32*i +: 32];
      end else if (we_s) begin
        rsp_q[0] <= rsp_d[31:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CMD:   bus_rdata <= {16'd0, start_q, failed_q, 2'b00, rt_q, 1'b0, h2c_q, c2h_q, idx_q};
        A_ARG:   bus_rdata <= arg_q;
        A_TMO:   bus_rdata <= 32'(tmo_q);
        A_DIV:   bus_rdata <= 32'(div_q);
        A_RSP0:  bus_rdata <= rsp_q[0];
        A_RSP1:  bus_rdata <= rsp_q[1];
        A_RSP2:  bus_rdata <= rsp_q[2];
        A_RSP3:  bus_rdata <= rsp_q[3];
        A_STAT:  bus_rdata <= {21'd0, stat_q};
        A_HCFG:  bus_rdata <= {21'd0, hcfg_q};
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_FAIL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(failed_q) |-> (stat_q[ST_CTO] | stat_q[ST_CRC] | stat_q[ST_BTO])); // R6
  AST_UPPER_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_q[1]) |-> $past(we_l)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(hcfg_q[ST_BUSY])); // R8
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CMD && in_flight) |=> ($stable(idx_q) && $stable(rt_q))); // R11
endmodule

// File: tb/sdh_cmd_engine_tb.sv
module sdh_cmd_engine_tb;
  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0, cmd_in = 1'b1, dat0_in = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sd_clk, cmd_out, cmd_oe, irq;
  int errors = 0, checks = 0;
  bit done_flag = 1'b0;
  logic [47:0] cap = '0;

  always #2.5 clk = ~clk;

  sdh_cmd_engine u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_clk(sd_clk),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in), .irq(irq));

  always @(posedge sd_clk) if (cmd_oe) cap <= {cap[46:0], cmd_out};

  function automatic logic [6:0] crc7_f(input logic [39:0] d);
    logic [6:0] c = 7'd0;
    logic fb;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] frame_f(input logic [1:0] hd, input logic [5:0] ix, input logic [31:0] a);
    return {hd, ix, a, crc7_f({hd, ix, a}), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic issue(input logic [5:0] ix, input logic [2:0] rt, input logic [31:0] a);
    wr(8'h20, 32'h7FF);
    wr(8'h04, a);
    wr(8'h00, {16'd0, 1'b1, 3'd0, rt, 3'd0, ix});
  endtask

  task automatic card_send(input logic [135:0] bits, input int n);
    @(negedge cmd_oe);
    repeat (2) @(negedge sd_clk);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge sd_clk); cmd_in = bits[i];
    end
    @(negedge sd_clk); cmd_in = 1'b1;
  endtask

  task automatic wait_done(output logic [31:0] c);
    for (int i = 0; i < 3000; i++) begin
      rd(8'h00, c);
      if (!c[15] || c[14]) break;
    end
  endtask

  initial begin
    #750000;
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    logic [47:0] f;
    logic [127:0] lv;
    int t0, per;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(8'h00, v); chk(v == 0, "R2 reset cmd word", v, 0);
    rd(8'h20, v); chk(v == 0, "R10 reset status", v, 0);
    chk(!irq && !cmd_oe, "R8 reset irq/oe", {irq, cmd_oe}, 0);

    // R1/R5 sweep of frames with no reply
    for (int k = 0; k < 8; k++) begin
      logic [5:0] ix = 6'((k * 23 + 1) % 64);
      logic [31:0] a = 32'h9E37_79B9 * (k + 1) ^ {26'd0, ix};
      issue(ix, 3'd2, a);
      rd(8'h00, v); chk(v[15] == 1'b1, "R2 start while in flight", v[15], 1);
      wait_done(c);
      chk(c[15:14] == 2'b00, "R5 none finishes", c[15:14], 0);
      chk(cap == frame_f(2'b01, ix, a), "R1 frame bits", cap, frame_f(2'b01, ix, a));
    end
    rd(8'h10, v); chk(v == 0, "R5 rsp0 untouched", v, 0);

    // R11 write during flight ignored
    issue(6'd9, 3'd2, 32'hCAFE_0001);
    wr(8'h00, {16'd0, 1'b1, 3'd0, 3'd2, 3'd0, 6'd33});
    wait_done(c);
    chk(c[5:0] == 6'd9, "R11 index kept", c[5:0], 9);
    chk(cap == frame_f(2'b01, 6'd9, 32'hCAFE_0001), "R11 frame kept", cap, frame_f(2'b01, 6'd9, 32'hCAFE_0001));

    // R4 long reply
    lv = {32'hA1A2A3A4, 32'hB1B2B3B4, 32'hC1C2C3C4, 32'hD1D2D3D5};
    issue(6'd2, 3'd1, 32'h0);
    card_send({2'b00, 6'h3F, lv}, 136);
    wait_done(c);
    chk(c[15:14] == 2'b00, "R4 long ok", c[15:14], 0);
    rd(8'h10, v); chk(v == lv[31:0], "R4 rsp0", v, lv[31:0]);
    rd(8'h14, v); chk(v == lv[63:32], "R4 rsp1", v, lv[63:32]);
    rd(8'h18, v); chk(v == lv[95:64], "R4 rsp2", v, lv[95:64]);
    rd(8'h1C, v); chk(v == lv[127:96], "R4 rsp3", v, lv[127:96]);

    // R3 short reply
    f = frame_f(2'b00, 6'd17, 32'h0000_0900);
    issue(6'd17, 3'd0, 32'h55);
    card_send({88'd0, f}, 48);
    wait_done(c);
    chk(c[15:14] == 2'b00, "R3 short ok", c[15:14], 0);
    rd(8'h10, v); chk(v == 32'h0000_0900, "R3 rsp0", v, 32'h900);
    rd(8'h14, v); chk(v == lv[63:32], "R3 rsp1 kept", v, lv[63:32]);
    rd(8'h1C, v); chk(v == lv[127:96], "R3 rsp3 kept", v, lv[127:96]);

    // R7 CRC error
    f = frame_f(2'b00, 6'd13, 32'h1234_5678) ^ 48'h4;
    issue(6'd13, 3'd0, 32'h1);
    card_send({88'd0, f}, 48);
    wait_done(c);
    chk(c[15:14] == 2'b11, "R7 failed", c[15:14], 3);
    rd(8'h20, v); chk(v == 32'h10, "R7 status", v, 32'h10);

    // R6 response timeout
    issue(6'd8, 3'd0, 32'h1AA);
    wait_done(c);
    chk(c[15:14] == 2'b11, "R6 failed", c[15:14], 3);
    rd(8'h20, v); chk(v == 32'h40, "R6 status", v, 32'h40);

    // R8 busy release
    wr(8'h08, 32'd200);
    dat0_in = 1'b0;
    f = frame_f(2'b00, 6'd7, 32'h0000_0700);
    issue(6'd7, 3'd4, 32'h0);
    card_send({88'd0, f}, 48);
    repeat (30) @(negedge clk);
    rd(8'h20, v); chk(v == 0, "R8 still busy", v, 0);
    dat0_in = 1'b1;
    wait_done(c);
    chk(c[15:14] == 2'b00, "R8 busy done", c[15:14], 0);
    rd(8'h20, v); chk(v == 32'h400, "R8 busy status", v, 32'h400);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(8'h38, 32'h400);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);
    // R10 write-one-to-clear
    wr(8'h20, 32'h1);
    rd(8'h20, v); chk(v == 32'h400, "R10 zero bits keep", v, 32'h400);
    wr(8'h20, 32'h400);
    rd(8'h20, v); chk(v == 0, "R10 cleared", v, 0);
    @(negedge clk); chk(irq == 1'b0, "R10 irq drops", irq, 0);

    // R9 busy timeout
    wr(8'h08, 32'd20);
    dat0_in = 1'b0;
    issue(6'd7, 3'd4, 32'h0);
    card_send({88'd0, f}, 48);
    wait_done(c);
    chk(c[15:14] == 2'b11, "R9 failed", c[15:14], 3);
    rd(8'h20, v); chk(v == 32'h80, "R9 status", v, 32'h80);
    dat0_in = 1'b1;

    // R12 divider
    for (int d = 0; d < 4; d++) begin
      wr(8'h0C, 32'(d));
      @(posedge sd_clk); @(posedge sd_clk);
      t0 = 0;
      fork
        begin @(posedge sd_clk); end
        begin forever begin @(posedge clk); t0++; end end
      join_any
      disable fork;
      per = 2 * (d + 1);
      chk(t0 == per, "R12 sd clock period", t0, per);
    end

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule